// File: doc/BRIEF.md
# Timer Compare Channel Reference Generator

This block is one output-compare channel of a general-purpose timer. It watches the counter value that the timer shares across its channels and compares it against a compare value held in its own registers. From that comparison it builds a registered reference waveform in one of two pulse-width modulation shapes. It also receives the counter wrap event (overflow or underflow), an update event, a trigger event and an asynchronous external clear input.

A small synchronous write port loads a configuration word and a compare value, and a combinational read port returns them. The compare value can be double-buffered: with preload on, software writes land in a buffer and the comparison keeps using the active value until the next update event. Two further options change the waveform. With immediate-active on, a trigger forces the reference to the mode's active level until the counter next wraps. With reference-clear on, a high external clear input drives the reference low.

Top module: `cmp_chan_out`

## Requirements
- R1: After reset, `ref_out` is 0 and both registers (address 0 configuration, address 1 compare) read back as 0.
- R2: A write to address 0 loads the configuration: bits [3:0] are the mode, bit 4 enables reference-clear, bit 5 enables preload, bit 6 enables immediate-active. A write to address 1 loads the compare value. A read of address 0 returns the configuration in those positions with the upper bits zero. A read of address 1 returns the last compare value written.
- R3: In mode 4'b0110 (PWM 1), `ref_out` is 1 when `cnt` is below the active compare value and 0 otherwise. It reflects the inputs of the previous cycle.
- R4: In mode 4'b0111 (PWM 2), `ref_out` is the inverse: 0 when `cnt` is below the active compare value and 1 otherwise.
- R5: In every other mode value, `ref_out` is held at 0.
- R6: With preload off, a compare write becomes the active value at the next clock edge and is used by the comparison in the following cycle.
- R7: With preload on, a compare write only fills the buffer and the active value is unchanged. On an update event the active value takes the buffer contents as they stood before any write in that same cycle.
- R8: With immediate-active on in PWM 1 or PWM 2, a trigger pulse forces `ref_out` to the active level (1 in PWM 1, 0 in PWM 2) from the next edge, regardless of the comparison.
- R9: The forced level ends at a `wrap_evt` pulse, after which `ref_out` follows the comparison again.
- R10: If a trigger and a wrap arrive in the same cycle, the trigger wins and the forced level starts, or continues.
- R11: A trigger has no effect when immediate-active is off or the mode is not PWM 1 or PWM 2, and leaves no pending force behind.
- R12: With reference-clear on, `ext_clr` passes through two flip-flops and then holds `ref_out` at 0 for as long as it stays high. A rise on `ext_clr` shows on `ref_out` after three edges. Clear takes priority over the forced level and over the comparison.
- R13: With reference-clear off, `ext_clr` has no effect on `ref_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Shared timer counter value |
| wrap_evt | input | 1 | Single-cycle counter overflow/underflow pulse |
| upd_evt | input | 1 | Single-cycle update event pulse |
| trig_evt | input | 1 | Single-cycle trigger event pulse |
| ext_clr | input | 1 | Asynchronous external clear level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 configuration, 1 compare |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| ref_out | output | 1 | Registered channel reference output |

## Verification
The hardest states to reach are those where several events land on one edge or contend for the reference. Examples are a trigger together with a wrap while a force is already running, and a clear that arrives while a force holds the reference high. The bench sets the compare value so that the plain comparison gives the level opposite to the forced or cleared one, which makes every override show directly at `ref_out`. Each event is a pulse driven on the falling edge, and each output is sampled a counted number of edges later. That counting covers the three-edge latency of the clear path, including the cycle just before the clear takes hold.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;

    typedef struct packed {
        logic       imm_en;
        logic       pre_en;
        logic       clr_en;
        logic [3:0] mode;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [3:0] MODE_PWM1 = 4'b0110;
    localparam logic [3:0] MODE_PWM2 = 4'b0111;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_CMP = 2'd1;

    function automatic logic is_pwm(input logic [3:0] m);
        return (m == MODE_PWM1) || (m == MODE_PWM2);
    endfunction

endpackage

// File: rtl/cmpch_sync.sv
module cmpch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.sh = {st_q.sh[STAGES-2:0], din};
        end else begin
            st_d.sh = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sh[STAGES-1];
endmodule

// File: rtl/cmpch_regs.sv
module cmpch_regs
    import cmpch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_evt,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cmp_act
);
    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] bufv;
        logic [CNT_W-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // update moves the buffer as it stood before this cycle's write
        if (upd_evt && st_q.cfg.pre_en) begin
            st_d.act = st_q.bufv;
        end
        if (wr_en && (wr_addr == ADDR_CFG)) begin
            st_d.cfg = cfg_t'(wr_data[CFG_W-1:0]);
        end
        if (wr_en && (wr_addr == ADDR_CMP)) begin
            st_d.bufv = wr_data;
            if (!st_q.cfg.pre_en) begin
                st_d.act = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign cmp_buf = st_q.bufv;
    assign cmp_act = st_q.act;
endmodule

// File: rtl/cmpch_refgen.sv
module cmpch_refgen
    import cmpch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             wrap_evt,
    input  logic             trig_evt,
    input  logic             clr_s,
    output logic             ref_out
);
    typedef struct packed {
        logic forced;
        logic refv;
    } st_t;

    st_t  st_d, st_q;
    logic below;
    logic pwm1;
    logic pwm2;

    always_comb begin
        st_d  = st_q;
        below = (cnt < cmp_act);
        pwm1  = (cfg.mode == MODE_PWM1);
        pwm2  = (cfg.mode == MODE_PWM2);

        // force state: trigger beats wrap, dropped outside PWM modes
        if (!is_pwm(cfg.mode) || !cfg.imm_en) begin
            st_d.forced = 1'b0;
        end else if (trig_evt) begin
            st_d.forced = 1'b1;
        end else if (wrap_evt) begin
            st_d.forced = 1'b0;
        end

        if (cfg.clr_en && clr_s) begin
            st_d.refv = 1'b0;
        end else if (pwm1) begin
            st_d.refv = st_d.forced ? 1'b1 : below;
        end else if (pwm2) begin
            st_d.refv = st_d.forced ? 1'b0 : !below;
        end else begin
            st_d.refv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_out = st_q.refv;
endmodule

// File: rtl/cmp_chan_out.sv
module cmp_chan_out
    import cmpch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap_evt,
    input  logic             upd_evt,
    input  logic             trig_evt,
    input  logic             ext_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             ref_out
);
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cmp_act;
    logic             clr_s;

    cmpch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clr),
        .dout (clr_s)
    );

    cmpch_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .upd_evt(upd_evt),
        .cfg    (cfg),
        .cmp_buf(cmp_buf),
        .cmp_act(cmp_act)
    );

    cmpch_refgen #(.CNT_W(CNT_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .cnt     (cnt),
        .cmp_act (cmp_act),
        .wrap_evt(wrap_evt),
        .trig_evt(trig_evt),
        .clr_s   (clr_s),
        .ref_out (ref_out)
    );

    always_comb begin
        case (rd_addr)
            ADDR_CFG: rd_data = CNT_W'(cfg);
            ADDR_CMP: rd_data = cmp_buf;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cmpch_chk.sv
module cmpch_chk
    import cmpch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input cfg_t             cfg,
    input logic             clr_s,
    input logic [CNT_W-1:0] cmp_act,
    input logic [CNT_W-1:0] cmp_buf,
    input logic             upd_evt,
    input logic             trig_evt,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             ref_out
);
    // R5
    a_r5_idle_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
        !is_pwm(cfg.mode) |=> !ref_out);

    // R12
    a_r12_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.clr_en && clr_s) |=> !ref_out);

    // R7
    a_r7_preload_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pre_en && !upd_evt) |=> $stable(cmp_act));

    // R7
    a_r7_update_moves_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pre_en && upd_evt) |=> (cmp_act == $past(cmp_buf)));

    // R6
    a_r6_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.pre_en && wr_en && wr_addr == ADDR_CMP) |=> (cmp_act == $past(wr_data)));

    // R8
    a_r8_trigger_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.imm_en && cfg.mode == MODE_PWM1 && trig_evt && !(cfg.clr_en && clr_s))
        |=> ref_out);
endmodule

bind cmp_chan_out cmpch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .clr_s   (clr_s),
    .cmp_act (cmp_act),
    .cmp_buf (cmp_buf),
    .upd_evt (upd_evt),
    .trig_evt(trig_evt),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ref_out (ref_out)
);

// File: tb/sim_cmp_chan_out.sv
module sim_cmp_chan_out;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         wrap_evt = 1'b0;
    logic         upd_evt = 1'b0;
    logic         trig_evt = 1'b0;
    logic         ext_clr = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         ref_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_chan_out #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap_evt(wrap_evt),
        .upd_evt(upd_evt), .trig_evt(trig_evt), .ext_clr(ext_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ref_out(ref_out)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ref_out=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_trig(input logic with_wrap);
        trig_evt = 1'b1; wrap_evt = with_wrap;
        step(1);
        trig_evt = 1'b0; wrap_evt = 1'b0;
    endtask

    task automatic pulse_wrap();
        wrap_evt = 1'b1;
        step(1);
        wrap_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk_bit("R1", ref_out, 1'b0);
        rd_addr = 2'd0; #1 chk_word("R1 cfg", rd_data, '0);
        rd_addr = 2'd1; #1 chk_word("R1 cmp", rd_data, '0);
    endtask

    task automatic t_regs();
        wr(2'd0, 16'h0076);
        wr(2'd1, 16'h1234);
        rd_addr = 2'd0; #1 chk_word("R2 cfg", rd_data, 16'h0076);
        rd_addr = 2'd1; #1 chk_word("R2 cmp", rd_data, 16'h1234);
        wr(2'd0, 16'hFF06);
        rd_addr = 2'd0; #1 chk_word("R2 cfg upper", rd_data, 16'h0006);
    endtask

    task automatic t_pwm();
        wr(2'd0, 16'h0006);
        wr(2'd1, 16'd100);
        cnt = 16'd50;  step(2); chk_bit("R3 below", ref_out, 1'b1);
        cnt = 16'd99;  step(1); chk_bit("R3 edge-1", ref_out, 1'b1);
        cnt = 16'd100; step(1); chk_bit("R3 equal", ref_out, 1'b0);
        cnt = 16'd150; step(1); chk_bit("R3 above", ref_out, 1'b0);
        wr(2'd0, 16'h0007);
        step(1); chk_bit("R4 above", ref_out, 1'b1);
        cnt = 16'd50; step(1); chk_bit("R4 below", ref_out, 1'b0);
        wr(2'd0, 16'h0000);
        step(1); chk_bit("R5 mode0", ref_out, 1'b0);
        wr(2'd0, 16'h0005); cnt = 16'd0;
        step(1); chk_bit("R5 mode5", ref_out, 1'b0);
    endtask

    task automatic t_preload();
        wr(2'd0, 16'h0006);
        cnt = 16'd150; step(1);
        chk_bit("R6 before", ref_out, 1'b0);
        wr(2'd1, 16'd200);
        step(1); chk_bit("R6 direct", ref_out, 1'b1);
        wr(2'd0, 16'h0026);
        wr(2'd1, 16'd100);
        step(2); chk_bit("R7 held", ref_out, 1'b1);
        rd_addr = 2'd1; #1 chk_word("R7 buf", rd_data, 16'd100);
        upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        step(1); chk_bit("R7 update", ref_out, 1'b0);
    endtask

    task automatic t_imm();
        wr(2'd0, 16'h0046);
        wr(2'd1, 16'd10);
        cnt = 16'd50; step(1);
        chk_bit("R8 pre", ref_out, 1'b0);
        pulse_trig(1'b0); chk_bit("R8 forced", ref_out, 1'b1);
        step(3); chk_bit("R8 hold", ref_out, 1'b1);
        pulse_wrap(); chk_bit("R9 end", ref_out, 1'b0);
        step(1); chk_bit("R9 stays", ref_out, 1'b0);
        pulse_trig(1'b1); chk_bit("R10 same cycle", ref_out, 1'b1);
        pulse_trig(1'b1); chk_bit("R10 during force", ref_out, 1'b1);
        step(1); chk_bit("R10 persists", ref_out, 1'b1);
        pulse_wrap(); chk_bit("R10 wrap after", ref_out, 1'b0);
        wr(2'd0, 16'h0047);
        wr(2'd1, 16'd100);
        cnt = 16'd150; step(1);
        chk_bit("R8 pwm2 pre", ref_out, 1'b1);
        pulse_trig(1'b0); chk_bit("R8 pwm2 forced", ref_out, 1'b0);
        pulse_wrap(); chk_bit("R9 pwm2 end", ref_out, 1'b1);
    endtask

    task automatic t_imm_ignored();
        wr(2'd1, 16'd10);
        cnt = 16'd50;
        wr(2'd0, 16'h0040);
        pulse_trig(1'b0); chk_bit("R11 mode0", ref_out, 1'b0);
        wr(2'd0, 16'h0046);
        step(1); chk_bit("R11 no pending", ref_out, 1'b0);
        wr(2'd0, 16'h0006);
        pulse_trig(1'b0); chk_bit("R11 imm off", ref_out, 1'b0);
    endtask

    task automatic t_clear();
        wr(2'd0, 16'h0056);
        wr(2'd1, 16'd100);
        cnt = 16'd50; step(1);
        chk_bit("R12 pre", ref_out, 1'b1);
        ext_clr = 1'b1;
        step(2); chk_bit("R12 latency", ref_out, 1'b1);
        step(1); chk_bit("R12 clear", ref_out, 1'b0);
        pulse_trig(1'b0); chk_bit("R12 beats force", ref_out, 1'b0);
        step(2); chk_bit("R12 held", ref_out, 1'b0);
        ext_clr = 1'b0;
        step(3); chk_bit("R12 release", ref_out, 1'b1);
        pulse_wrap();
        cnt = 16'd150; step(1);
        chk_bit("R13 pre", ref_out, 1'b0);
        cnt = 16'd50;
        wr(2'd0, 16'h0006);
        ext_clr = 1'b1;
        step(5); chk_bit("R13 ignored", ref_out, 1'b1);
        ext_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_pwm();
        t_preload();
        t_imm();
        t_imm_ignored();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule